// File: doc/BRIEF.md
# Button-Stepped Display Contrast PWM

This block produces a fixed-frequency pulse-width-modulated output. After an external RC filter and charge circuit, that output sets the contrast bias voltage of a character display. A prescaler turns the system clock into a 1 us tick. A period counter steps on that tick through 20 positions, which gives a 50 kHz output. The output is high from the start of each period until the counter reaches the active duty value.

The duty value is adjusted by two active-low push-buttons, "raise" and "lower". Both pass through a two-flop synchroniser. A slow tick, every 100 ms by default, samples them. On each sample the raise request is applied first and the lower request second, each only if it keeps the value inside an asymmetric window of 3 to 19. A new duty value is copied into the comparator only when the period counter wraps, so no period is ever cut short or stretched.

Top module: `lcd_bias_pwm`

## Requirements
- R1: After reset the duty output reads 10 and the PWM output is high, because the period counter starts at position 0.
- R2: One PWM period lasts PERIOD_TICKS (20) microsecond ticks. The counter runs 0 to 19 and then returns to 0.
- R3: In each period the output is high for exactly as many microsecond ticks as the active duty value, starting at the wrap. Over any whole period that is duty × CLK_KHZ/1000 clocks.
- R4: At a sample with the raise button low (pressed), the duty rises by 1 if it is below 19. At 19 it stays.
- R5: At a sample with the lower button low (pressed), the duty falls by 1 if, after the raise step, it is above 3. At 3 it stays.
- R6: With both buttons low at one sample, raise is applied before lower. From 19 the result is 18. From 3 the result is 3. Between the limits the value does not move.
- R7: The buttons act only at the slow sample tick. A press that starts and ends between two ticks, or buttons left released (high), do not change the duty.
- R8: A new duty value reaches the comparator only at a period wrap. Within a period the active compare value is constant.
- R9: The microsecond tick fires every CLK_KHZ/1000 clocks. The sample tick fires every SAMPLE_US microsecond ticks and always coincides with a microsecond tick.
- R10: The duty output never leaves the range 3 to 19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up_n | input | 1 | Raise button, low when pressed, asynchronous |
| btn_dn_n | input | 1 | Lower button, low when pressed, asynchronous |
| pwm_o | output | 1 | Contrast PWM output |
| duty_o | output | $clog2(PERIOD_TICKS+1) | Current duty register value |

## Verification
Suppose the duty register takes a wrong step or breaks a clamp. `duty_o` then shows the wrong value right after the sample edge, which is a full sample interval before the next chance to correct it. Suppose instead the counter, the prescaler or the shadow compare value is wrong. The number of high clocks in a whole period then differs from duty × clocks-per-tick, and this shows up in the first whole period after the change. A misplaced sample tick or a wrong button order moves the duty sequence away from the arithmetic model within one sample interval.

// File: rtl/lcd_bias_pwm_pkg.sv
package lcd_bias_pwm_pkg;

  // Duty update for one sample: raise first, then lower, each clamped.
  function automatic int step_duty(int cur, logic raise, logic lower, int lo, int hi);
    int v;
    v = cur;
    if (raise && v < hi) v = v + 1;
    if (lower && v > lo) v = v - 1;
    return v;
  endfunction

  // Output level for a counter position against the active compare value.
  function automatic logic pwm_level(int pos, int cmp);
    return pos < cmp;
  endfunction

  // Width helper that never returns zero.
  function automatic int width_of(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lbp_ticks.sv
module lbp_ticks #(
  parameter int US_DIV    = 8,
  parameter int SAMPLE_US = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick_o,
  output logic smp_tick_o
);
  import lcd_bias_pwm_pkg::*;

  localparam int PW = width_of(US_DIV);
  localparam int SW = width_of(SAMPLE_US);
  localparam logic [PW-1:0] P_LAST = PW'(US_DIV - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SAMPLE_US - 1);

  logic [PW-1:0] pre_q;
  logic [SW-1:0] smp_q;

  assign us_tick_o  = (pre_q == P_LAST);
  assign smp_tick_o = us_tick_o && (smp_q == S_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (us_tick_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else if (us_tick_o) begin
      smp_q <= (smp_q == S_LAST) ? '0 : smp_q + 1'b1;
    end
  end

endmodule

// File: rtl/lbp_sync.sv
module lbp_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;           // released level
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/lbp_duty.sv
module lbp_duty #(
  parameter int DUTY_W     = 5,
  parameter int DUTY_RESET = 10,
  parameter int DUTY_MIN   = 3,
  parameter int DUTY_MAX   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick_i,
  input  logic              up_n_i,
  input  logic              dn_n_i,
  output logic [DUTY_W-1:0] duty_o
);
  import lcd_bias_pwm_pkg::*;

  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] duty_next;

  always_comb begin
    duty_next = DUTY_W'(step_duty(int'(duty_q), ~up_n_i, ~dn_n_i, DUTY_MIN, DUTY_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= DUTY_W'(DUTY_RESET);
    end else if (smp_tick_i) begin
      duty_q <= duty_next;
    end
  end

  assign duty_o = duty_q;

endmodule

// File: rtl/lbp_pwm_core.sv
module lbp_pwm_core #(
  parameter int PERIOD_TICKS = 20,
  parameter int DUTY_W       = 5,
  parameter int DUTY_RESET   = 10,
  parameter int CNT_W        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DUTY_W-1:0] act_o,
  output logic              wrap_o,
  output logic              pwm_o
);
  import lcd_bias_pwm_pkg::*;

  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DUTY_W-1:0] act_q;

  assign wrap_o = us_tick_i && (cnt_q == C_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= DUTY_W'(DUTY_RESET);
    end else if (us_tick_i) begin
      if (wrap_o) begin
        cnt_q <= '0;
        act_q <= duty_i;          // shadow load only at wrap
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pwm_o = pwm_level(int'(cnt_q), int'(act_q));
  assign cnt_o = cnt_q;
  assign act_o = act_q;

endmodule

// File: rtl/lcd_bias_pwm.sv
module lcd_bias_pwm #(
  parameter int CLK_KHZ      = 8000,
  parameter int PERIOD_TICKS = 20,
  parameter int SAMPLE_US    = 100000,
  parameter int DUTY_RESET   = 10,
  parameter int DUTY_MIN     = 3,
  parameter int DUTY_MAX     = 19
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              btn_up_n,
  input  logic                              btn_dn_n,
  output logic                              pwm_o,
  output logic [$clog2(PERIOD_TICKS+1)-1:0] duty_o
);
  import lcd_bias_pwm_pkg::*;

  localparam int US_DIV = CLK_KHZ / 1000;
  localparam int DUTY_W = $clog2(PERIOD_TICKS + 1);
  localparam int CNT_W  = width_of(PERIOD_TICKS);

  logic              us_tick;
  logic              smp_tick;
  logic [1:0]        btn_s;
  logic              up_n_s;
  logic              dn_n_s;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  cnt;
  logic [DUTY_W-1:0] act_duty;
  logic              wrap;

  lbp_ticks #(.US_DIV(US_DIV), .SAMPLE_US(SAMPLE_US)) ticks_i (
    .clk(clk), .rst_n(rst_n), .us_tick_o(us_tick), .smp_tick_o(smp_tick)
  );

  lbp_sync #(.N(2), .STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i({btn_dn_n, btn_up_n}), .sync_o(btn_s)
  );

  assign up_n_s = btn_s[0];
  assign dn_n_s = btn_s[1];

  lbp_duty #(
    .DUTY_W(DUTY_W), .DUTY_RESET(DUTY_RESET), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
  ) duty_i (
    .clk(clk), .rst_n(rst_n), .smp_tick_i(smp_tick),
    .up_n_i(up_n_s), .dn_n_i(dn_n_s), .duty_o(duty)
  );

  lbp_pwm_core #(
    .PERIOD_TICKS(PERIOD_TICKS), .DUTY_W(DUTY_W), .DUTY_RESET(DUTY_RESET), .CNT_W(CNT_W)
  ) core_i (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .duty_i(duty),
    .cnt_o(cnt), .act_o(act_duty), .wrap_o(wrap), .pwm_o(pwm_o)
  );

  assign duty_o = duty;

endmodule

// File: rtl/lcd_bias_pwm_chk.sv
module lcd_bias_pwm_chk #(
  parameter int PERIOD_TICKS = 20,
  parameter int DUTY_MIN     = 3,
  parameter int DUTY_MAX     = 19,
  parameter int DUTY_W       = 5,
  parameter int CNT_W        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              us_tick,
  input logic              smp_tick,
  input logic              wrap,
  input logic              up_n_s,
  input logic              dn_n_s,
  input logic [CNT_W-1:0]  cnt,
  input logic [DUTY_W-1:0] act_duty,
  input logic [DUTY_W-1:0] duty,
  input logic              pwm_o
);
  localparam logic [DUTY_W-1:0] D_LO  = DUTY_W'(DUTY_MIN);
  localparam logic [DUTY_W-1:0] D_HI  = DUTY_W'(DUTY_MAX);
  localparam logic [CNT_W-1:0]  C_TOP = CNT_W'(PERIOD_TICKS);

  p_duty_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    duty >= D_LO && duty <= D_HI);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < C_TOP);

  p_sample_on_us_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |-> us_tick);

  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_tick |=> $stable(duty));

  p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick && !up_n_s && dn_n_s && duty < D_HI |=> duty == $past(duty) + 1'b1);

  p_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick && up_n_s && !dn_n_s && duty > D_LO |=> duty == $past(duty) - 1'b1);

  p_both_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick && !up_n_s && !dn_n_s && duty < D_HI |=> $stable(duty));

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_duty));

  p_wrap_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pwm_o);

endmodule

bind lcd_bias_pwm lcd_bias_pwm_chk #(
  .PERIOD_TICKS(PERIOD_TICKS), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX),
  .DUTY_W(DUTY_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .smp_tick(smp_tick), .wrap(wrap),
  .up_n_s(up_n_s), .dn_n_s(dn_n_s), .cnt(cnt), .act_duty(act_duty),
  .duty(duty), .pwm_o(pwm_o)
);

// File: tb/lcd_bias_pwm_tb_top.sv
module lcd_bias_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 2000;
  localparam int DIV        = CLK_KHZ / 1000;
  localparam int PER        = 20;
  localparam int SMP_US     = 100;
  localparam int SMP_CLK    = SMP_US * DIV;
  localparam int MID        = SMP_CLK / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up_n = 1'b1;
  logic       dn_n = 1'b1;
  logic       pwm;
  logic [4:0] duty;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int model  = 10;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  lcd_bias_pwm #(
    .CLK_KHZ(CLK_KHZ), .PERIOD_TICKS(PER), .SAMPLE_US(SMP_US),
    .DUTY_RESET(10), .DUTY_MIN(3), .DUTY_MAX(19)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_up_n(up_n), .btn_dn_n(dn_n),
    .pwm_o(pwm), .duty_o(duty)
  );

  function automatic int next_model(int d, bit up, bit dn);
    int r;
    r = d;
    if (up) r = (r >= 19) ? 19 : r + 1;
    if (dn) r = (r <= 3) ? 3 : r - 1;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_mid();
    @(negedge clk);
    while ((cyc % SMP_CLK) != MID) @(negedge clk);
  endtask

  // high clocks over one whole period, measured mid-interval (R3, R2, R8)
  task automatic check_pwm(string req);
    int hi;
    hi = 0;
    for (int i = 0; i < PER * DIV; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    check(req, hi, model * DIV);
  endtask

  // hold buttons across n samples, checking duty after each (R4 R5 R6)
  task automatic press(bit up, bit dn, int n, string req);
    go_mid();
    up_n = ~up;
    dn_n = ~dn;
    for (int k = 0; k < n; k++) begin
      repeat (SMP_CLK) @(negedge clk);
      model = next_model(model, up, dn);
      check(req, int'(duty), model);
    end
    up_n = 1'b1;
    dn_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 duty", int'(duty), 10);
    check("R1 pwm", int'(pwm), 1);
    // R9: first sample at clock SMP_CLK, released buttons: no change (R7)
    go_mid();
    check("R7 released", int'(duty), 10);
    check_pwm("R3 duty10");
    // R4 raise sweep to the clamp
    press(1'b1, 1'b0, 11, "R4 raise");
    go_mid();
    check_pwm("R3 duty19");
    // R6 both at 19 -> 18, then held
    press(1'b1, 1'b1, 3, "R6 both_hi");
    // R5 lower sweep to the clamp
    press(1'b0, 1'b1, 18, "R5 lower");
    go_mid();
    check_pwm("R3 duty3");
    // R6 both at 3 -> stays 3
    press(1'b1, 1'b1, 2, "R6 both_lo");
    // R7 short press between samples is ignored
    go_mid();
    up_n = 1'b0;
    repeat (MID / 2) @(negedge clk);
    up_n = 1'b1;
    go_mid();
    check("R7 short", int'(duty), model);
    // step to a mid value, then verify each period width (R8, R9)
    for (int s = 0; s < 6; s++) begin
      press(1'b1, 1'b0, 1, "R4 step");
      go_mid();
      check_pwm("R8 period");
    end
    press(1'b1, 1'b1, 2, "R6 both_mid");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule